// File: doc/BRIEF.md
# Metering Pulse Width Limiter

The block turns pulse requests from a metering engine into low-going pulses on one output line. Each request starts a low pulse. The pulse lasts 2*N+1 time units, where N is the 8-bit maximum-width code. The time unit comes from one of two sources. If the interval code is zero, it is the sample-rate tick. If the interval code is not zero, the block divides a base interval tick by that code. The width code 255 switches width control off. In that mode every request flips the output, which gives a 50% duty waveform when the requests arrive at a steady rate.

Both codes are held in two registers inside the block. A one-cycle write strobe with a one-bit address loads them. After reset the width code is 255 (toggle mode) and the interval code is zero.

With a zero interval code the block runs in direct mode. Pulses start at once, and a request that arrives during a pulse is dropped. With a non-zero interval code the block runs in queued mode. Requests that arrive during a pulse or during the recovery gap that follows it are counted. Each counted request is issued after the line has stayed high for one whole time unit.

The controller has four states:
- IDLE: line high, waiting.
- LOW: pulse in progress.
- GAP: high recovery time in queued mode.
- HALF: line low in toggle mode.

The transitions are:
- fire: IDLE to LOW.
- enter-half: IDLE to HALF.
- end-direct: LOW to IDLE.
- end-queued: LOW to GAP.
- refire: GAP to LOW.
- gap-done: GAP to IDLE.
- flush: GAP to IDLE.
- leave-half: HALF to IDLE.

Top module: `pulse_width_limiter`

## Requirements
- R1: After reset, `pulse_n_o` is 1, the width code is 255 and the interval code is 0.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_wdata` is written to the width code if `cfg_addr` is 0, or to the interval code if `cfg_addr` is 1. The new value is used from the next cycle.
- R3: With an interval code of 0, the time unit tick is `samp_tick_i`. With an interval code M > 0, a divider counts `base_tick_i` pulses from 0. Every M-th base tick is a unit tick, and the divider then goes back to 0.
- R4: A request in IDLE with width code N < 255 drives `pulse_n_o` low from the next cycle. The line goes high again after the edge at which the (2N+1)-th unit tick is seen during the pulse.
- R5: With width code 255, a request in IDLE drives the line low, and the next request drives it high again (toggle).
- R6: With an interval code of 0, a request that arrives while the line is low is ignored. After the pulse ends, the block returns to IDLE.
- R7: With an interval code other than 0, a request that arrives in LOW or GAP is counted. The count saturates at 2^PEND_W-1. When a pulse ends, the block enters GAP.
- R8: A change of the width code during a pulse does not change that pulse. It applies to the next pulse that starts.
- R9: In GAP, at the next unit tick, the block starts a new pulse if the count, including a request in that same cycle, is not zero. The count then drops by one. Otherwise the block returns to IDLE.
- R10: If the width code is 255 at the unit tick in GAP, the count is cleared and the block returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 selects the width code, 1 selects the interval code |
| cfg_wdata | input | CFG_W | Register write data |
| req_i | input | 1 | One-cycle pulse request |
| base_tick_i | input | 1 | Base interval tick, divided by the interval code |
| samp_tick_i | input | 1 | Sample-rate tick |
| pulse_n_o | output | 1 | Active-low pulse output |

## Verification
Three events can fall in the same clock cycle: a new request, the unit tick that ends a pulse, and the unit tick that ends the recovery gap. When the ending tick and a request coincide, the request must be queued or dropped depending on the mode. When the gap tick and a request coincide, the request must be launched immediately. The bench causes these collisions with a dense phase of random requests and a fast base tick in queued mode, and with a deliberate burst of requests against a slow sample tick in direct mode. A behavioural model with a request queue predicts the output line on every cycle, and any mismatch is reported against the requirement of the phase that is running.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_GAP  = 2'd2,
        ST_HALF = 2'd3
    } pwl_state_t;

endpackage

// File: rtl/pwl_cfg_regs.sv
module pwl_cfg_regs #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] maxw,
    output logic [CFG_W-1:0] intv
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maxw <= '1;
            intv <= '0;
        end else if (we) begin
            if (addr) begin
                intv <= wdata;
            end else begin
                maxw <= wdata;
            end
        end
    end

endmodule

// File: rtl/pwl_timebase.sv
module pwl_timebase #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] intv,
    input  logic             base_tick,
    input  logic             samp_tick,
    output logic             unit_tick
);

    localparam int EXT_W = CFG_W + 1;

    logic [CFG_W-1:0] div_cnt;
    logic [EXT_W-1:0] div_inc;
    logic             direct;
    logic             wrap;

    assign direct  = (intv == '0);
    assign div_inc = {1'b0, div_cnt} + EXT_W'(1);
    assign wrap    = base_tick && (div_inc >= {1'b0, intv});

    always_comb begin
        if (direct) begin
            unit_tick = samp_tick;
        end else begin
            unit_tick = wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (direct) begin
            div_cnt <= '0;
        end else if (base_tick) begin
            if (wrap) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_inc[CFG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pwl_width_ctr.sv
module pwl_width_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    assign last = dec && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwl_fsm.sv
module pwl_fsm
    import pwl_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              unit_tick,
    input  logic              width_last,
    input  logic              queue_mode,
    input  logic              toggle_sel,
    output pwl_state_t        state,
    output logic              load,
    output logic [PEND_W-1:0] pend,
    output logic              pulse_n
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    pwl_state_t state_nxt;
    logic       accept;
    logic       consume;
    logic       clear;
    logic       pend_any;
    logic       pend_up;

    assign accept   = queue_mode && req && ((state == ST_LOW) || (state == ST_GAP));
    assign pend_any = (pend != '0) || accept;
    assign pend_up  = accept && (pend != PEND_MAX);

    // transition selection
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        consume   = 1'b0;
        clear     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (toggle_sel) begin
                        state_nxt = ST_HALF;               // enter-half
                    end else begin
                        state_nxt = ST_LOW;                // fire
                        load      = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (width_last) begin
                    state_nxt = queue_mode ? ST_GAP : ST_IDLE; // end-queued / end-direct
                end
            end
            ST_GAP: begin
                if (unit_tick) begin
                    if (toggle_sel) begin
                        state_nxt = ST_IDLE;               // flush
                        clear     = 1'b1;
                    end else if (pend_any) begin
                        state_nxt = ST_LOW;                // refire
                        load      = 1'b1;
                        consume   = 1'b1;
                    end else begin
                        state_nxt = ST_IDLE;               // gap-done
                    end
                end
            end
            ST_HALF: begin
                if (req) begin
                    state_nxt = ST_IDLE;                   // leave-half
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // pending request counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (clear) begin
            pend <= '0;
        end else begin
            pend <= pend + (pend_up ? PEND_W'(1) : PEND_W'(0))
                         - (consume ? PEND_W'(1) : PEND_W'(0));
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_LOW, ST_HALF: pulse_n = 1'b0;
            default:         pulse_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/pulse_width_limiter.sv
module pulse_width_limiter
    import pwl_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int PEND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_i,
    input  logic             base_tick_i,
    input  logic             samp_tick_i,
    output logic             pulse_n_o
);

    localparam int CNT_W = CFG_W + 1;

    logic [CFG_W-1:0]  maxw_reg;
    logic [CFG_W-1:0]  intv_reg;
    logic              unit_tick;
    logic [CNT_W-1:0]  width_cnt;
    logic [CNT_W-1:0]  width_init;
    logic              width_last;
    logic              width_load;
    logic              queue_mode;
    logic              toggle_sel;
    logic [PEND_W-1:0] pend_cnt;
    pwl_state_t        state;

    assign queue_mode = (intv_reg != '0);
    assign toggle_sel = (maxw_reg == '1);
    assign width_init = {maxw_reg, 1'b1};

    pwl_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .maxw  (maxw_reg),
        .intv  (intv_reg)
    );

    pwl_timebase #(.CFG_W(CFG_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .intv      (intv_reg),
        .base_tick (base_tick_i),
        .samp_tick (samp_tick_i),
        .unit_tick (unit_tick)
    );

    pwl_width_ctr #(.CNT_W(CNT_W)) u_wc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (width_load),
        .load_val (width_init),
        .dec      (unit_tick),
        .cnt      (width_cnt),
        .last     (width_last)
    );

    pwl_fsm #(.PEND_W(PEND_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_i),
        .unit_tick  (unit_tick),
        .width_last (width_last),
        .queue_mode (queue_mode),
        .toggle_sel (toggle_sel),
        .state      (state),
        .load       (width_load),
        .pend       (pend_cnt),
        .pulse_n    (pulse_n_o)
    );

endmodule

// File: rtl/pwl_checker.sv
module pwl_checker
    import pwl_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              unit_tick,
    input logic              pulse_n_o,
    input pwl_state_t        state,
    input logic [CFG_W:0]    width_cnt,
    input logic [PEND_W-1:0] pend_cnt,
    input logic [CFG_W-1:0]  maxw_reg,
    input logic [CFG_W-1:0]  intv_reg
);

    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_n_o) |-> ($past(req_i) || ($past(state) == ST_GAP))); // R4

    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == ST_LOW) && (state != ST_LOW)) |-> $past(unit_tick)); // R4

    AST_LOW_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> (width_cnt != '0)); // R4

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOW) && !unit_tick) |=> (state == ST_LOW)); // R8

    AST_QUEUE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt > $past(pend_cnt)) |-> ($past(intv_reg) != '0)); // R7

    AST_HALF_NEEDS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALF) && ($past(state) == ST_IDLE)) |-> ($past(maxw_reg) == '1)); // R5

    AST_DIRECT_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOW) && unit_tick && (width_cnt == 1) && (intv_reg == '0))
        |=> (state == ST_IDLE)); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GAP) && unit_tick && (maxw_reg == '1))
        |=> ((pend_cnt == '0) && (state == ST_IDLE))); // R10

endmodule

bind pulse_width_limiter pwl_checker #(.CFG_W(CFG_W), .PEND_W(PEND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .unit_tick (unit_tick),
    .pulse_n_o (pulse_n_o),
    .state     (state),
    .width_cnt (width_cnt),
    .pend_cnt  (pend_cnt),
    .maxw_reg  (maxw_reg),
    .intv_reg  (intv_reg)
);

// File: tb/pulse_width_limiter_bench.sv
`timescale 1ns/1ps
module pulse_width_limiter_bench;

    localparam int CFG_W  = 8;
    localparam int PEND_W = 4;
    localparam int PMAX   = (1 << PEND_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_addr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             req_i = 1'b0;
    logic             base_tick_i = 1'b0;
    logic             samp_tick_i = 1'b0;
    logic             pulse_n_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int base_div = 2;
    string cur_req = "R1";

    // reference model state
    int m_maxw, m_intv, m_div, m_mode, m_left;
    int m_q[$];
    bit m_out;

    always #2 clk = ~clk;

    pulse_width_limiter #(.CFG_W(CFG_W), .PEND_W(PEND_W)) u_pulse_width_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .req_i       (req_i),
        .base_tick_i (base_tick_i),
        .samp_tick_i (samp_tick_i),
        .pulse_n_o   (pulse_n_o)
    );

    // tick sources
    always @(negedge clk) begin
        cyc = cyc + 1;
        samp_tick_i <= (cyc % 7 == 0);
        base_tick_i <= (cyc % base_div == 0);
    end

    // behavioural reference, updated at the active edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_maxw = 255; m_intv = 0; m_div = 0; m_mode = 0; m_left = 0;
            m_q.delete();
        end else begin
            bit ut;
            bit acc;
            if (m_intv == 0) ut = samp_tick_i;
            else ut = base_tick_i && (m_div + 1 >= m_intv);
            acc = (m_intv != 0) && req_i && (m_mode == 1 || m_mode == 2);
            if (acc && m_q.size() < PMAX) m_q.push_back(cyc);
            case (m_mode)
                0: if (req_i) begin
                       if (m_maxw == 255) m_mode = 3;
                       else begin m_mode = 1; m_left = 2 * m_maxw + 1; end
                   end
                1: if (ut) begin
                       m_left = m_left - 1;
                       if (m_left == 0) m_mode = (m_intv != 0) ? 2 : 0;
                   end
                2: if (ut) begin
                       if (m_maxw == 255) begin m_q.delete(); m_mode = 0; end
                       else if (m_q.size() > 0) begin
                           void'(m_q.pop_front());
                           m_mode = 1; m_left = 2 * m_maxw + 1;
                       end else m_mode = 0;
                   end
                default: if (req_i) m_mode = 0;
            endcase
            if (m_intv == 0) m_div = 0;
            else if (base_tick_i) m_div = (m_div + 1 >= m_intv) ? 0 : m_div + 1;
            if (cfg_we) begin
                if (cfg_addr) m_intv = cfg_wdata;
                else m_maxw = cfg_wdata;
            end
        end
        m_out = !(m_mode == 1 || m_mode == 3);
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pulse_n_o !== m_out) begin
                bad++;
                $display("FAIL %s cycle %0d: pulse_n_o actual=%0b expected=%0b",
                         cur_req, cyc, pulse_n_o, m_out);
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input bit a, input int d);
        @(negedge clk);
        cfg_we <= 1'b1; cfg_addr <= a; cfg_wdata <= d[CFG_W-1:0];
        @(negedge clk);
        cfg_we <= 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        req_i <= 1'b1;
        @(negedge clk);
        req_i <= 1'b0;
    endtask

    // watchdog
    initial begin
        wait_cyc(150000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1: reset state seen at the port
        checks++;
        if (pulse_n_o !== 1'b1) begin
            bad++;
            $display("FAIL R1: pulse_n_o actual=%0b expected=1", pulse_n_o);
        end

        // R5: reset width code 255 gives toggle mode
        cur_req = "R5";
        pulse_req(); wait_cyc(10);
        pulse_req(); wait_cyc(10);
        pulse_req(); wait_cyc(4);
        pulse_req(); wait_cyc(6);

        // R2 and R4: direct mode with width code 2, then 0
        cur_req = "R2";
        wr(1'b0, 2);
        cur_req = "R4";
        pulse_req(); wait_cyc(60);
        wr(1'b0, 0);
        pulse_req(); wait_cyc(20);

        // R6: requests while low in direct mode are dropped
        cur_req = "R6";
        wr(1'b0, 3);
        pulse_req(); wait_cyc(3);
        pulse_req(); wait_cyc(5);
        pulse_req(); wait_cyc(70);

        // R3: interval code 3 divides the base tick
        cur_req = "R3";
        wr(1'b1, 3);
        wr(1'b0, 1);
        pulse_req(); wait_cyc(40);

        // R7: burst during a low pulse is queued with gaps
        cur_req = "R7";
        pulse_req(); pulse_req(); pulse_req(); pulse_req();
        wait_cyc(150);

        // R8: width change mid-pulse applies to the next pulse
        cur_req = "R8";
        wr(1'b0, 4);
        pulse_req(); wait_cyc(4);
        wr(1'b0, 0);
        pulse_req(); wait_cyc(120);

        // R10: switch to 255 while requests are pending
        cur_req = "R10";
        wr(1'b0, 2);
        pulse_req(); pulse_req(); pulse_req();
        wait_cyc(3);
        wr(1'b0, 255);
        wait_cyc(80);
        pulse_req(); wait_cyc(5);
        pulse_req(); wait_cyc(5);

        // R9: dense random requests collide with gap and end ticks
        cur_req = "R9";
        wr(1'b0, 1);
        wr(1'b1, 1);
        base_div = 3;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            req_i <= ($urandom_range(0, 3) == 0);
        end
        @(negedge clk); req_i <= 1'b0;
        wr(1'b1, 2);
        base_div = 2;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            req_i <= ($urandom_range(0, 5) == 0);
        end
        @(negedge clk); req_i <= 1'b0;
        wait_cyc(200);

        // R6 again: dense requests in direct mode with a slow tick
        cur_req = "R6";
        wr(1'b1, 0);
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            req_i <= ($urandom_range(0, 4) == 0);
        end
        @(negedge clk); req_i <= 1'b0;
        wait_cyc(100);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule